// File: doc/BRIEF.md
# Sleep and Wake Power Sequencer

This controller moves a processor subsystem from run mode into sleep and back again. Software raises a sleep request. The sequencer then holds the peripherals in reset and moves the GPIO pins onto their programmed sleep values. It also floats the memory and chip-select pins as configured and, in the standard mode, drops the external regulator enable. A wake event brings the subsystem back. In standard mode the return includes a supply stabilization wait. The fast mode keeps the supply up during sleep and uses a much shorter wait.

The block runs entirely on the slow oscillator clock, so every delay is a tick count. The tick counts are parameters so that simulation stays short. The active-low supply and battery fault inputs pass through a two-flop synchronizer. While the subsystem is running they can raise a single-cycle imprecise-abort request, which software then uses to enter sleep. During a fast wake-up, a supply fault sends the controller straight back to sleep.

Top module: `sleep_wake_seq`

## Requirements
- R1: After reset the block is in run mode. running_o=1, pwr_en_o=1, and periph_rst_o, gpio_sleep_sel_o, abort_req_o and wake_done_o are all 0. float_o is 2'b00.
- R2: A sleep request is accepted only in run mode.
  - In the cycle after acceptance, running_o=0 and periph_rst_o=1.
  - After ENTER_TICKS ticks the block is in sleep, shown by gpio_sleep_sel_o=1.
  - A request raised in any other mode has no effect.
- R3: In standard mode (fast_wake_i=0 at the request), pwr_en_o is 0 in sleep.
  - A wake event returns running_o=1 exactly STAB_TICKS+2 ticks after the clock edge that first samples it.
  - pwr_en_o is 1 from the first tick of the wait onward.
- R4: Fast mode is selected only when fast_wake_i=1 and osc_pd_i=0, both sampled at the sleep request.
  - In fast mode pwr_en_o stays 1 through sleep, and wake-up takes FAST_TICKS+2 ticks.
  - With osc_pd_i=1 the block behaves as in standard mode.
- R5: In fast mode, if the synchronized supply fault is low during the wake wait or the wake-done tick, the block returns to sleep.
  - It stays in sleep until a new wake event arrives while the supply fault is high.
- R6: A wake event starts wake-up only in sleep and only while the synchronized supply fault is high. Wake events in run mode have no effect.
- R7: periph_rst_o is 1 through sleep entry, sleep and the wake wait.
  - It is 0 during the wake-done tick, which is the tick before the one in which wake_done_o is asserted.
  - wake_done_o is a single-cycle pulse in the first run tick.
- R8: gpio_sleep_sel_o is 1 in sleep and during the wake wait. gpio_sleep_val_o then shows gpio_sleep_val_i as sampled at the sleep request.
- R9: float_o carries float_cfg_i as sampled at the sleep request and is cleared to 0 on the return to run mode.
- R10: In run mode with abort_en_i=1, a falling edge of either synchronized fault raises abort_req_o for exactly one cycle.
  - The pulse is not repeated while the fault stays low.
  - With abort_en_i=0 no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow oscillator clock, one tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Software sleep request |
| wake_evt_i | input | NUM_WAKE | Wake event sources, any high wakes |
| supply_fault_ni | input | 1 | Supply fault, active low |
| batt_fault_ni | input | 1 | Battery fault, active low |
| fast_wake_i | input | 1 | Select fast wake-up |
| osc_pd_i | input | 1 | Oscillator power-down in sleep |
| abort_en_i | input | 1 | Enable abort request on faults |
| float_cfg_i | input | 2 | Float select for memory and chip-select pins |
| gpio_sleep_val_i | input | NUM_GPIO | GPIO levels to drive in sleep |
| pwr_en_o | output | 1 | Regulator power enable |
| periph_rst_o | output | 1 | Peripheral reset hold |
| gpio_sleep_sel_o | output | 1 | Drive GPIO pins from sleep values |
| gpio_sleep_val_o | output | NUM_GPIO | Captured GPIO sleep values |
| float_o | output | 2 | Applied float control |
| abort_req_o | output | 1 | Imprecise-abort request pulse |
| running_o | output | 1 | Block is in run mode |
| wake_done_o | output | 1 | Pulse on return to run mode |

## Verification
Full sleep-wake cycles are run with three configurations: fast off, fast on with the oscillator kept running, and fast on with the oscillator powered down. Timing each wake to the exact tick tells the stabilization path apart from the short path, and shows that the power-down bit forces the long path. Faults are applied in two places: during sleep, to block a wake event, and during a fast wake wait, to force a return to sleep. Abort stimuli cover a held-low fault, a fault on each input, and a disabled enable, which separates edge-triggered single pulses from level-driven repeats.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;
  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_ENTER     = 3'd1,
    ST_SLEEP     = 3'd2,
    ST_WAKE_WAIT = 3'd3,
    ST_WAKE_DONE = 3'd4
  } seq_state_e;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int NUM_IN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] fault_ni,
  output logic [NUM_IN-1:0] level_o,
  output logic [NUM_IN-1:0] fall_o
);
  logic [NUM_IN-1:0] s1_q, s2_q, prev_q;

  // reset to deasserted (high) so no edge is seen out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
    end else begin
      s1_q   <= fault_ni;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign fall_o  = prev_q & ~s2_q;

  a_r10_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |fall_o |=> ((fall_o & $past(fall_o)) == '0));
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic             done_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  a_r3_timer_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !done_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq
  import sleep_wake_pkg::*;
#(
  parameter int NUM_WAKE    = 4,
  parameter int NUM_GPIO    = 8,
  parameter int ENTER_TICKS = 3,
  parameter int STAB_TICKS  = 20,
  parameter int FAST_TICKS  = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sleep_req_i,
  input  logic [NUM_WAKE-1:0] wake_evt_i,
  input  logic                supply_fault_ni,
  input  logic                batt_fault_ni,
  input  logic                fast_wake_i,
  input  logic                osc_pd_i,
  input  logic                abort_en_i,
  input  logic [1:0]          float_cfg_i,
  input  logic [NUM_GPIO-1:0] gpio_sleep_val_i,
  output logic                pwr_en_o,
  output logic                periph_rst_o,
  output logic                gpio_sleep_sel_o,
  output logic [NUM_GPIO-1:0] gpio_sleep_val_o,
  output logic [1:0]          float_o,
  output logic                abort_req_o,
  output logic                running_o,
  output logic                wake_done_o
);
  localparam int MAX_TICKS = (STAB_TICKS > ENTER_TICKS) ?
                             ((STAB_TICKS > FAST_TICKS) ? STAB_TICKS : FAST_TICKS) :
                             ((ENTER_TICKS > FAST_TICKS) ? ENTER_TICKS : FAST_TICKS);
  localparam int TW = $clog2(MAX_TICKS + 1);

  seq_state_e          state_q, state_d;
  logic                fast_q;
  logic [NUM_GPIO-1:0] gpio_q;
  logic [1:0]          float_q;
  logic                abort_q, done_q;
  logic [1:0]          flt_lvl, flt_fall;
  logic                sup_ok;
  logic                tmr_load, tmr_done;
  logic [TW-1:0]       tmr_val;

  fault_sync #(.NUM_IN(2)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fault_ni ({batt_fault_ni, supply_fault_ni}),
    .level_o  (flt_lvl),
    .fall_o   (flt_fall)
  );
  assign sup_ok = flt_lvl[0];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:       if (sleep_req_i) state_d = ST_ENTER;
      ST_ENTER:     if (tmr_done) state_d = ST_SLEEP;
      ST_SLEEP:     if (|wake_evt_i && sup_ok) state_d = ST_WAKE_WAIT;
      ST_WAKE_WAIT: if (fast_q && !sup_ok) state_d = ST_SLEEP;
                    else if (tmr_done) state_d = ST_WAKE_DONE;
      ST_WAKE_DONE: if (fast_q && !sup_ok) state_d = ST_SLEEP;
                    else state_d = ST_RUN;
      default:      state_d = ST_RUN;
    endcase
  end

  assign tmr_load = (state_d != state_q);
  always_comb begin
    tmr_val = '0;
    if (state_d == ST_ENTER)     tmr_val = TW'(ENTER_TICKS - 1);
    if (state_d == ST_WAKE_WAIT) tmr_val = fast_q ? TW'(FAST_TICKS - 1) : TW'(STAB_TICKS - 1);
  end

  tick_timer #(.WIDTH(TW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      fast_q  <= 1'b0;
      gpio_q  <= '0;
      float_q <= '0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN && sleep_req_i) begin
        fast_q  <= fast_wake_i & ~osc_pd_i;
        gpio_q  <= gpio_sleep_val_i;
        float_q <= float_cfg_i;
      end else if (state_d == ST_RUN && state_q != ST_RUN) begin
        float_q <= '0;
      end
      abort_q <= (state_q == ST_RUN) && abort_en_i && (|flt_fall);
      done_q  <= (state_q == ST_WAKE_DONE) && (state_d == ST_RUN);
    end
  end

  assign running_o        = (state_q == ST_RUN);
  assign periph_rst_o     = (state_q == ST_ENTER) || (state_q == ST_SLEEP) ||
                            (state_q == ST_WAKE_WAIT);
  assign gpio_sleep_sel_o = (state_q == ST_SLEEP) || (state_q == ST_WAKE_WAIT);
  assign gpio_sleep_val_o = gpio_q;
  assign float_o          = float_q;
  assign pwr_en_o         = (state_q != ST_SLEEP) || fast_q;
  assign abort_req_o      = abort_q;
  assign wake_done_o      = done_q;

  a_r2_req_only_from_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTER) |-> ($past(state_q) inside {ST_RUN, ST_ENTER}));
  a_r5_fast_fault_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q inside {ST_WAKE_WAIT, ST_WAKE_DONE}) && fast_q && !sup_ok) |=> (state_q == ST_SLEEP));
  a_r6_wake_needs_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_SLEEP && state_q == ST_WAKE_WAIT) |-> $past(sup_ok));
  a_r7_done_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |-> (running_o && !$past(periph_rst_o) && !$past(running_o)));
  a_r7_sel_implies_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpio_sleep_sel_o |-> periph_rst_o);
  a_r9_float_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |-> (float_o == 2'b00));
  a_r10_abort_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_req_o |=> !abort_req_o);
endmodule

// File: tb/sim_sleep_wake_seq.sv
module sim_sleep_wake_seq;
  localparam int NW = 4, NG = 8, ENT = 3, STAB = 20, FAST = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_req = 1'b0;
  logic [NW-1:0] wake_evt = '0;
  logic          sup_n = 1'b1, bat_n = 1'b1;
  logic          fast = 1'b0, oscpd = 1'b0, abt_en = 1'b0;
  logic [1:0]    fcfg = 2'b00;
  logic [NG-1:0] gval = '0;
  logic          pwr_en, prst, gsel, abort_req, running, wdone;
  logic [NG-1:0] gout;
  logic [1:0]    fout;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sleep_wake_seq #(.NUM_WAKE(NW), .NUM_GPIO(NG), .ENTER_TICKS(ENT),
                   .STAB_TICKS(STAB), .FAST_TICKS(FAST)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .wake_evt_i(wake_evt),
    .supply_fault_ni(sup_n), .batt_fault_ni(bat_n), .fast_wake_i(fast),
    .osc_pd_i(oscpd), .abort_en_i(abt_en), .float_cfg_i(fcfg),
    .gpio_sleep_val_i(gval), .pwr_en_o(pwr_en), .periph_rst_o(prst),
    .gpio_sleep_sel_o(gsel), .gpio_sleep_val_o(gout), .float_o(fout),
    .abort_req_o(abort_req), .running_o(running), .wake_done_o(wdone)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // request sleep with given capture values, check entry
  task automatic enter_sleep(logic [1:0] f, logic [NG-1:0] g);
    fcfg = f; gval = g; sleep_req = 1'b1;
    tick(1);
    sleep_req = 1'b0; fcfg = ~f; gval = ~g;
    chk("R2 running after req", running, 0);
    chk("R7 rst in entry", prst, 1);
    chk("R8 sel off in entry", gsel, 0);
    tick(ENT);
    chk("R2 in sleep after ENTER_TICKS", gsel, 1);
    chk("R8 gpio captured", gout, g);
    chk("R9 float captured", fout, f);
  endtask

  // pulse wake and return tick count to running
  task automatic wake_time(output int n, input int exp_pwr);
    logic prev_rst;
    wake_evt = 4'b0100; n = 0; prev_rst = prst;
    do begin
      prev_rst = prst;
      tick(1);
      wake_evt = '0;
      n++;
      if (n == 1) chk("R3 pwr on in wait", pwr_en, exp_pwr);
    end while (!running && n < 200);
    chk("R7 rst released tick before done", prev_rst, 0);
    chk("R7 done pulse", wdone, 1);
    chk("R9 float cleared", fout, 0);
    tick(1);
    chk("R7 done single", wdone, 0);
  endtask

  task automatic t_reset();
    chk("R1 running", running, 1);
    chk("R1 pwr", pwr_en, 1);
    chk("R1 rst", prst, 0);
    chk("R1 sel", gsel, 0);
    chk("R1 float", fout, 0);
    chk("R1 abort", abort_req, 0);
    chk("R1 done", wdone, 0);
  endtask

  task automatic t_run_ignores();
    wake_evt = 4'b1111;
    tick(3);
    wake_evt = '0;
    chk("R6 wake in run ignored", running, 1);
    chk("R6 no rst from wake in run", prst, 0);
  endtask

  task automatic t_standard();
    int n;
    fast = 1'b0; oscpd = 1'b0;
    enter_sleep(2'b10, 8'hA5);
    chk("R3 pwr off in sleep", pwr_en, 0);
    sleep_req = 1'b1;
    tick(2);
    sleep_req = 1'b0;
    chk("R2 req in sleep ignored", gsel, 1);
    wake_time(n, 1);
    chk("R3 standard wake ticks", n, STAB + 2);
  endtask

  task automatic t_fast();
    int n;
    fast = 1'b1; oscpd = 1'b0;
    enter_sleep(2'b01, 8'h3C);
    fast = 1'b0;
    chk("R4 pwr kept in fast sleep", pwr_en, 1);
    wake_time(n, 1);
    chk("R4 fast wake ticks", n, FAST + 2);
  endtask

  task automatic t_fast_oscpd();
    int n;
    fast = 1'b1; oscpd = 1'b1;
    enter_sleep(2'b11, 8'h0F);
    fast = 1'b0; oscpd = 1'b0;
    chk("R4 osc pd drops pwr", pwr_en, 0);
    wake_time(n, 1);
    chk("R4 osc pd uses full delay", n, STAB + 2);
  endtask

  task automatic t_fast_fault();
    int n;
    fast = 1'b1; oscpd = 1'b0;
    enter_sleep(2'b01, 8'h81);
    wake_evt = 4'b0001;
    tick(1);
    wake_evt = '0;
    chk("R8 sel in wake wait", gsel, 1);
    sup_n = 1'b0;
    tick(10);
    chk("R5 fault aborts fast wake", running, 0);
    chk("R5 back in sleep rst", prst, 1);
    chk("R5 back in sleep sel", gsel, 1);
    sup_n = 1'b1;
    tick(12);
    chk("R5 needs new wake event", running, 0);
    wake_time(n, 1);
    chk("R5 rewake ticks", n, FAST + 2);
    chk("R10 no abort outside run", abort_req, 0);
  endtask

  task automatic t_fault_blocks();
    int n;
    fast = 1'b0;
    enter_sleep(2'b10, 8'h55);
    sup_n = 1'b0;
    tick(3);
    wake_evt = 4'b1000;
    tick(1);
    wake_evt = '0;
    tick(4);
    chk("R6 wake blocked by fault", gsel, 1);
    chk("R6 pwr still off", pwr_en, 0);
    sup_n = 1'b1;
    tick(3);
    wake_time(n, 1);
    chk("R6 wake after fault clears", n, STAB + 2);
  endtask

  task automatic count_abort(int cyc, output int cnt);
    cnt = 0;
    for (int i = 0; i < cyc; i++) begin
      tick(1);
      if (abort_req) cnt++;
    end
  endtask

  task automatic t_abort();
    int c;
    abt_en = 1'b1;
    bat_n = 1'b0;
    count_abort(8, c);
    chk("R10 batt fault one pulse", c, 1);
    count_abort(8, c);
    chk("R10 held fault no repeat", c, 0);
    bat_n = 1'b1;
    tick(4);
    sup_n = 1'b0;
    count_abort(8, c);
    chk("R10 supply fault one pulse", c, 1);
    sup_n = 1'b1;
    tick(4);
    abt_en = 1'b0;
    bat_n = 1'b0;
    count_abort(8, c);
    chk("R10 disabled no pulse", c, 0);
    bat_n = 1'b1;
    tick(4);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_run_ignores();
    t_standard();
    t_fast();
    t_fast_oscpd();
    t_fast_fault();
    t_fault_blocks();
    t_abort();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule